// File: doc/BRIEF.md
# Waveform Raster Display Generator

This block paints a stored waveform of 256 samples, together with a division grid, onto a progressive video raster of 312 lines per frame. An external sync generator supplies the pixel clock, a single-cycle blanking strobe at each line boundary and a frame-sync strobe. From these the block finds a square active window of 256 lines by 256 pixel positions. It counts lines and pixels inside that window and supplies the pixel count as the read address of a sample memory.

The memory returns the sample for the current column one clock after the address. The block lights a trace dot where that sample equals the current line index, so sample 0 appears on the top active line and sample 255 on the bottom line. A grid pixel is lit wherever the low bits of the line index or of the pixel index are all zero. Both flags, and a window flag aligned with them, come out of flip-flops and are ready for a downstream video mixer.

Top module: `scope_raster_gen`

## Requirements
- R1: After a frame-sync strobe the first 16 blanking strobes are skipped. The active window opens in the clock after the 16th one, and `mem_raddr` starts counting from that clock.
- R2: The window lasts exactly 256 lines and closes in the clock after the 272nd blanking strobe following frame sync. Blanking strobes that come after that have no effect until the next frame sync.
- R3: Inside the window `mem_raddr` is 0 in the first clock of each line. It rises by one every clock, holds at 255, and returns to 0 in the clock after a blanking strobe. Outside the window it is 0.
- R4: Frame sync takes precedence over a blanking strobe in the same clock and restarts the skip count, even in the middle of the window. After reset, no window opens until a frame-sync strobe has been seen.
- R5: `trace_px` is high in clock t+2 exactly when the window was open in clock t and the `mem_rdata` value in clock t+1 equals the line index (0 = top line) of clock t. Here `mem_raddr` of clock t is the address read.
- R6: `grat_px` is high in clock t+2 exactly when the window was open in clock t and bits [4:0] of the line index or of `mem_raddr` were all zero in clock t.
- R7: `active_area` in clock t+2 equals the window state in clock t. `trace_px` and `grat_px` are never high while `active_area` is low.
- R8: While `rst` (active high, synchronous) is asserted, all outputs are 0 in the clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_pulse | input | 1 | One-cycle strobe at each line boundary |
| frame_sync | input | 1 | One-cycle strobe at the start of each frame |
| mem_rdata | input | 8 | Sample returned for the address of the previous clock |
| mem_raddr | output | 8 | Sample memory read address (pixel index) |
| trace_px | output | 1 | Registered trace dot flag |
| grat_px | output | 1 | Registered grid pixel flag |
| active_area | output | 1 | Registered display-window flag, aligned with the pixel flags |

## Verification
The assertions assume that the blanking and frame-sync strobes last one clock each and are separate. They also assume that the sample memory has exactly one clock of read latency. The stimulus keeps to this: every line starts with a single blanking cycle, frame sync always gets a clock of its own, and the modelled memory registers its output on the address edge. Frames include surplus lines after the window and a restart in the middle of the window, so both ends of the line sequencing are exercised under these assumptions.

// File: rtl/scope_raster_pkg.sv
package scope_raster_pkg;
   typedef enum logic [1:0] {
      PH_WAIT   = 2'd0,
      PH_SKIP   = 2'd1,
      PH_ACTIVE = 2'd2
   } raster_phase_t;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/scope_line_seq.sv
module scope_line_seq
   import scope_raster_pkg::*;
#(
   parameter int unsigned SKIP_LINES = 16,
   parameter int unsigned LINE_W     = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              blank_pulse,
   input  logic              frame_sync,
   output logic              active,
   output logic [LINE_W-1:0] line_idx
);
   localparam int unsigned SKIP_W = bits_for(SKIP_LINES);
   localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(SKIP_LINES - 1);
   localparam logic [LINE_W-1:0] LINE_LAST = {LINE_W{1'b1}};

   raster_phase_t     phase_q;
   logic [SKIP_W-1:0] skip_q;
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_WAIT;
         skip_q  <= '0;
         line_q  <= '0;
      end else if (frame_sync) begin
         phase_q <= PH_SKIP;
         skip_q  <= '0;
         line_q  <= '0;
      end else if (blank_pulse) begin
         unique case (phase_q)
            PH_SKIP: begin
               if (skip_q == SKIP_LAST) begin
                  phase_q <= PH_ACTIVE;
                  line_q  <= '0;
               end else begin
                  skip_q <= skip_q + 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (line_q == LINE_LAST) begin
                  phase_q <= PH_WAIT;
                  line_q  <= '0;
               end else begin
                  line_q <= line_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign active   = (phase_q == PH_ACTIVE);
   assign line_idx = line_q;

   // R1: the window only opens on a blanking strobe, never on frame sync
   a_r1_enter_on_blank: assert property (@(posedge clk) disable iff (rst)
      $rose(active) |-> ($past(blank_pulse) && !$past(frame_sync)));

   // R4: frame sync always closes the window in the next clock
   a_r4_sync_closes: assert property (@(posedge clk) disable iff (rst)
      frame_sync |=> !active);

   // R2: without a strobe the line index does not move
   a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
      (active && !blank_pulse && !frame_sync) |=> (active && $stable(line_idx)));
endmodule

// File: rtl/scope_pix_cnt.sv
module scope_pix_cnt #(
   parameter int unsigned PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active,
   input  logic             blank_pulse,
   input  logic             frame_sync,
   output logic [PIX_W-1:0] pix_idx
);
   localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

   logic [PIX_W-1:0] pix_q;

   always_ff @(posedge clk) begin
      if (rst || frame_sync || !active || blank_pulse) begin
         pix_q <= '0;
      end else if (pix_q != PIX_MAX) begin
         pix_q <= pix_q + 1'b1;
      end
   end

   assign pix_idx = pix_q;

   // R3: count stays at zero outside the window
   a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !active |-> (pix_idx == '0));

   // R3: a blanking strobe inside the window restarts the line
   a_r3_clear_on_blank: assert property (@(posedge clk) disable iff (rst)
      (active && blank_pulse) |=> (pix_idx == '0));

   // R3: the count saturates at its top value
   a_r3_hold_max: assert property (@(posedge clk) disable iff (rst)
      (active && !blank_pulse && !frame_sync && pix_idx == PIX_MAX) |=> (pix_idx == PIX_MAX));
endmodule

// File: rtl/scope_px_stage.sv
module scope_px_stage #(
   parameter int unsigned LINE_W    = 8,
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned SAMPLE_W  = 8,
   parameter int unsigned GRID_BITS = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                active,
   input  logic [LINE_W-1:0]   line_idx,
   input  logic [PIX_W-1:0]    pix_idx,
   input  logic [SAMPLE_W-1:0] rdata,
   output logic                trace_px,
   output logic                grat_px,
   output logic                area_px
);
   logic              act1;
   logic [LINE_W-1:0] line1;
   logic [PIX_W-1:0]  pix1;
   logic              grid_hit;
   logic              trace_hit;

   // address stage: hold coordinates while the memory answers
   always_ff @(posedge clk) begin
      if (rst) begin
         act1  <= 1'b0;
         line1 <= '0;
         pix1  <= '0;
      end else begin
         act1  <= active;
         line1 <= line_idx;
         pix1  <= pix_idx;
      end
   end

   generate
      if (GRID_BITS == 0) begin : g_no_grid
         assign grid_hit = 1'b0;
      end else begin : g_grid
         assign grid_hit = (line1[GRID_BITS-1:0] == '0) || (pix1[GRID_BITS-1:0] == '0);
      end
   endgenerate

   assign trace_hit = (rdata == line1);

   // compare stage: registered flags, gated by the window
   always_ff @(posedge clk) begin
      if (rst) begin
         trace_px <= 1'b0;
         grat_px  <= 1'b0;
         area_px  <= 1'b0;
      end else begin
         trace_px <= act1 && trace_hit;
         grat_px  <= act1 && grid_hit;
         area_px  <= act1;
      end
   end

   // R7: no pixel flag outside the window
   a_r7_flags_need_area: assert property (@(posedge clk) disable iff (rst)
      (trace_px || grat_px) |-> area_px);

   // R6: the first column of every active line is a grid pixel
   a_r6_first_column: assert property (@(posedge clk) disable iff (rst)
      (act1 && pix1 == '0) |=> grat_px);
endmodule

// File: rtl/scope_raster_gen.sv
module scope_raster_gen #(
   parameter int unsigned SKIP_LINES = 16,
   parameter int unsigned LINE_W     = 8,
   parameter int unsigned PIX_W      = 8,
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned GRID_BITS  = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                blank_pulse,
   input  logic                frame_sync,
   input  logic [SAMPLE_W-1:0] mem_rdata,
   output logic [PIX_W-1:0]    mem_raddr,
   output logic                trace_px,
   output logic                grat_px,
   output logic                active_area
);
   localparam int unsigned MIN_W = (LINE_W < PIX_W) ? LINE_W : PIX_W;

   generate
      if (SKIP_LINES < 1) begin : g_bad_skip
         $error("SKIP_LINES must be at least 1");
      end
      if (SAMPLE_W != LINE_W) begin : g_bad_sample
         $error("SAMPLE_W must equal LINE_W for the vertical match");
      end
      if (GRID_BITS > MIN_W) begin : g_bad_grid
         $error("GRID_BITS exceeds the counter width");
      end
   endgenerate

   logic              active;
   logic [LINE_W-1:0] line_idx;
   logic [PIX_W-1:0]  pix_idx;

   scope_line_seq #(
      .SKIP_LINES (SKIP_LINES),
      .LINE_W     (LINE_W)
   ) u_line (
      .clk         (clk),
      .rst         (rst),
      .blank_pulse (blank_pulse),
      .frame_sync  (frame_sync),
      .active      (active),
      .line_idx    (line_idx)
   );

   scope_pix_cnt #(
      .PIX_W (PIX_W)
   ) u_pix (
      .clk         (clk),
      .rst         (rst),
      .active      (active),
      .blank_pulse (blank_pulse),
      .frame_sync  (frame_sync),
      .pix_idx     (pix_idx)
   );

   scope_px_stage #(
      .LINE_W    (LINE_W),
      .PIX_W     (PIX_W),
      .SAMPLE_W  (SAMPLE_W),
      .GRID_BITS (GRID_BITS)
   ) u_px (
      .clk      (clk),
      .rst      (rst),
      .active   (active),
      .line_idx (line_idx),
      .pix_idx  (pix_idx),
      .rdata    (mem_rdata),
      .trace_px (trace_px),
      .grat_px  (grat_px),
      .area_px  (active_area)
   );

   assign mem_raddr = pix_idx;
endmodule

// File: tb/scope_raster_gen_tb.sv
module scope_raster_gen_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       blank_pulse = 1'b0;
   logic       frame_sync = 1'b0;
   logic [7:0] mem_rdata;
   logic [7:0] mem_raddr;
   logic       trace_px, grat_px, active_area;

   always #10 clk = ~clk;

   scope_raster_gen u_dut (
      .clk (clk), .rst (rst), .blank_pulse (blank_pulse), .frame_sync (frame_sync),
      .mem_rdata (mem_rdata), .mem_raddr (mem_raddr),
      .trace_px (trace_px), .grat_px (grat_px), .active_area (active_area)
   );

   // sample memory with one clock of read latency
   logic [7:0] mem [256];
   always @(posedge clk) mem_rdata <= mem[mem_raddr];

   // reference model built from the requirement text
   int         nb = -1;          // blanking strobes since frame sync, -1 = none seen
   int         pix_m = 0;
   logic       a1 = 0, e_act = 0, e_trace = 0, e_grat = 0;
   logic [7:0] l1 = 0, p1 = 0;
   wire        win_m  = (nb >= 16) && (nb < 272);
   wire  [7:0] line_m = win_m ? 8'(nb - 16) : 8'd0;

   always @(posedge clk) begin
      if (rst) begin
         nb <= -1; pix_m <= 0;
         a1 <= 0; l1 <= 0; p1 <= 0; e_act <= 0; e_trace <= 0; e_grat <= 0;
      end else begin
         if (frame_sync || !win_m || blank_pulse) pix_m <= 0;
         else if (pix_m < 255) pix_m <= pix_m + 1;
         if (frame_sync) nb <= 0;
         else if (blank_pulse && nb >= 0 && nb < 272) nb <= nb + 1;
         a1 <= win_m; l1 <= line_m; p1 <= 8'(pix_m);
         e_act   <= a1;
         e_trace <= a1 && (mem_rdata == l1);
         e_grat  <= a1 && ((l1[4:0] == 5'd0) || (p1[4:0] == 5'd0));
      end
   end

   int  n_tests = 0, n_fail = 0;
   bit  cmp_en = 0;
   int  err_act, err_addr, err_trace, err_grat, err_low;
   int  cnt_act, cnt_trace, cnt_grat;

   always @(negedge clk) begin
      if (cmp_en) begin
         if (active_area !== e_act) err_act++;
         if (mem_raddr !== 8'(pix_m)) err_addr++;
         if (trace_px !== e_trace) err_trace++;
         if (grat_px !== e_grat) err_grat++;
         if ((trace_px || grat_px) && !active_area) err_low++;
         cnt_act   += int'(active_area);
         cnt_trace += int'(trace_px);
         cnt_grat  += int'(grat_px);
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_counts();
      err_act = 0; err_addr = 0; err_trace = 0; err_grat = 0; err_low = 0;
      cnt_act = 0; cnt_trace = 0; cnt_grat = 0;
   endtask

   task automatic check_model(input string tag);
      check("R1", {tag, " window mismatches"}, err_act, 0);
      check("R3", {tag, " address mismatches"}, err_addr, 0);
      check("R5", {tag, " trace mismatches"}, err_trace, 0);
      check("R6", {tag, " grid mismatches"}, err_grat, 0);
      check("R7", {tag, " flags outside window"}, err_low, 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_line(input int len);
      @(negedge clk) blank_pulse = 1'b1;
      @(negedge clk) blank_pulse = 1'b0;
      idle(len - 2);
   endtask

   task automatic send_sync();
      @(negedge clk) frame_sync = 1'b1;
      @(negedge clk) frame_sync = 1'b0;
   endtask

   // R8, R4: reset state and no window without frame sync
   task automatic t_reset();
      rst = 1'b1;
      idle(3);
      check("R8", "raddr in reset", int'(mem_raddr), 0);
      check("R8", "flags in reset", int'({trace_px, grat_px, active_area}), 0);
      rst = 1'b0;
      clear_counts(); cmp_en = 1;
      for (int i = 0; i < 30; i++) send_line(20);
      idle(3);
      cmp_en = 0;
      check("R4", "window cycles without frame sync", cnt_act, 0);
      check_model("no-sync");
   endtask

   // R1, R2, R3, R5, R6: full frame, diagonal samples, long lines
   task automatic t_full_frame();
      for (int i = 0; i < 256; i++) mem[i] = 8'(i);
      clear_counts(); cmp_en = 1;
      send_sync();
      for (int i = 0; i < 300; i++) send_line(270);
      idle(4);
      cmp_en = 0;
      check("R2", "window cycles per frame", cnt_act, 256 * 270);
      check("R5", "diagonal trace dots", cnt_trace, 270);
      check("R6", "grid pixels", cnt_grat, 8 * 270 + 248 * 8);
      check_model("full-frame");
   endtask

   // R5: sample 0 is the top line, sample 255 the bottom line
   task automatic t_extremes();
      for (int i = 0; i < 256; i++) mem[i] = (i % 2 == 0) ? 8'd0 : 8'd255;
      clear_counts(); cmp_en = 1;
      send_sync();
      for (int i = 0; i < 290; i++) send_line(40);
      idle(4);
      cmp_en = 0;
      check("R5", "top and bottom dots", cnt_trace, 40);
      check("R2", "window cycles short lines", cnt_act, 256 * 40);
      check_model("extremes");
   endtask

   // R4: frame sync in mid-window restarts the skip, also together with blank
   task automatic t_resync();
      for (int i = 0; i < 256; i++) mem[i] = 8'(255 - i);
      clear_counts(); cmp_en = 1;
      send_sync();
      for (int i = 0; i < 60; i++) send_line(40);
      idle(5);
      @(negedge clk) begin frame_sync = 1'b1; blank_pulse = 1'b1; end
      @(negedge clk) begin frame_sync = 1'b0; blank_pulse = 1'b0; end
      idle(3);
      check("R4", "window closed after resync", int'(active_area), 0);
      for (int i = 0; i < 15; i++) send_line(40);
      idle(4);
      check("R4", "window still closed after 15 lines", int'(active_area), 0);
      for (int i = 0; i < 3; i++) send_line(40);
      check("R1", "window reopened", int'(active_area), 1);
      idle(3);
      cmp_en = 0;
      check_model("resync");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'd0;
      t_reset();
      t_full_frame();
      t_extremes();
      t_resync();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule